// File: doc/BRIEF.md
# Serial PHY Management Controller

This block runs IEEE 802.3 clause-22 management transactions on the MDC/MDIO pair. It is controlled through one 32-bit command/status word. Software writes a PHY address, a register number, an opcode and, for a write, a 16-bit value. The controller then shifts the complete frame out, serially and MSB-first.

A read transaction gives up MDIO at the turnaround point. The controller then collects the PHY's sixteen data bits on rising MDC edges and places them in the low half of the same word. When the transaction finishes, the controller sets a ready flag in the word and pulses a completion event for one cycle, which an interrupt block can collect.

MDC is derived from the system clock by a parameterised divider. It is held low whenever no transaction is running.

Top module: `mgmt_serial_ctl`

## Requirements
- R1: After reset the command word reads 0x1000_0000, which means only the ready flag (bit 28) is set. MDC is low, MDIO is not driven and the completion event is low.
- R2: The command word has this layout:
  - bits 15:0 hold the data;
  - bits 20:16 hold the register number;
  - bits 25:21 hold the PHY address;
  - bits 27:26 hold the opcode (01 = write, 10 = read);
  - bit 28 is the ready flag;
  - bits 31:29 read as zero.
  Writing opcode 01 or 10 while ready is set launches a transaction, and ready reads 0 from the next cycle.
- R3: A write frame is sampled on rising MDC edges and contains, in order: PRE_LEN ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and the 16 data bits. All fields are sent MSB-first, and MDIO is driven for every bit.
- R4: A read frame drives only its first PRE_LEN+14 bits. MDIO is released for the two turnaround bits and the 16 data bits. The controller samples MDIO on rising MDC edges, MSB-first, and the result appears in bits 15:0 once ready returns to 1. The address, register and opcode fields keep their values.
- R5: One MDC period lasts 2*DIV_HALF system clocks, and a transaction lasts exactly PRE_LEN+32 MDC periods. While ready is set, MDC stays low and MDIO is not driven.
- R6: When a transaction ends, ready returns to 1. The completion event pulses high for exactly one cycle, in the same cycle that ready returns.
- R7: A write to the command word while ready is 0 is ignored. No fields change, and no second frame is sent.
- R8: A write with opcode 00 or 11 stores its fields but starts no frame. Ready stays 1, MDC does not toggle, and no completion event is raised.
- R9: After a write transaction, the command word reads back the written data, address, register and opcode, with ready set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Value written to the command word |
| reg_rdata | output | 32 | Current command/status word |
| done_evt | output | 1 | One-cycle completion event |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The checker assumes two things about the inputs:
- the write strobe lasts a single clock and carries a stable value in that clock;
- MDIO input changes only while MDC is low, never near the rising edge where the controller samples it.

The bench keeps to both. It pulses the strobe for one cycle, away from the clock edge. Its PHY model changes MDIO only on falling MDC edges, which are whole half-periods away from the next rising edge. Opcodes 00 and 11 are sent deliberately, to show that they start nothing.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int MGMT_ADR_W  = 5;
   localparam int MGMT_DAT_W  = 16;
   localparam int MGMT_HDR_W  = 14;   // start + opcode + phy + reg
   localparam int MGMT_TAIL_W = 18;   // turnaround + data
   localparam int BIT_RDY     = 28;

   typedef enum logic [1:0] {
      OPC_NONE0 = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_NONE3 = 2'b11
   } mgmt_opc_e;

   typedef struct packed {
      mgmt_opc_e               opc;
      logic [MGMT_ADR_W-1:0]   phy;
      logic [MGMT_ADR_W-1:0]   rno;
      logic [MGMT_DAT_W-1:0]   dat;
   } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_p,
   output logic fall_p
);
   logic edge_p;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign edge_p = run;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt;
         assign edge_p = run && (cnt == CW'(DIV_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt <= '0;
            else if (!run || edge_p)  cnt <= '0;
            else                      cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mdc <= 1'b0;
      else if (!run)   mdc <= 1'b0;
      else if (edge_p) mdc <= ~mdc;
   end

   assign rise_p = edge_p && !mdc;
   assign fall_p = edge_p &&  mdc;
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  mgmt_cmd_t             cmd,
   input  logic                  rise_p,
   input  logic                  fall_p,
   input  logic                  mdio_i,
   output logic                  run,
   output logic                  fin,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic [MGMT_DAT_W-1:0] cap
);
   localparam int FRM  = PRE_LEN + MGMT_HDR_W + MGMT_TAIL_W;
   localparam int IW   = $clog2(FRM);
   localparam int REL  = PRE_LEN + MGMT_HDR_W;
   localparam int DAT  = REL + 2;
   localparam int LAST = FRM - 1;

   logic [FRM-1:0] shreg;
   logic [IW-1:0]  idx;
   logic           rd_q;
   logic           is_rd;
   logic [FRM-1:0] frame;

   assign is_rd = (cmd.opc == OPC_READ);
   assign frame = {{PRE_LEN{1'b1}}, 2'b01, cmd.opc, cmd.phy, cmd.rno,
                   (is_rd ? 2'b11 : 2'b10),
                   (is_rd ? {MGMT_DAT_W{1'b0}} : cmd.dat)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         fin   <= 1'b0;
         shreg <= '0;
         idx   <= '0;
         rd_q  <= 1'b0;
         cap   <= '0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            run   <= 1'b1;
            idx   <= '0;
            rd_q  <= is_rd;
            shreg <= frame;
            cap   <= '0;
         end else if (run) begin
            if (rise_p && rd_q && (idx >= IW'(DAT)))
               cap <= {cap[MGMT_DAT_W-2:0], mdio_i};
            if (fall_p) begin
               if (idx == IW'(LAST)) begin
                  run <= 1'b0;
                  fin <= 1'b1;
               end else begin
                  idx   <= idx + 1'b1;
                  shreg <= {shreg[FRM-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mdio_o  = run & shreg[FRM-1];
   assign mdio_oe = run && !(rd_q && (idx >= IW'(REL)));
endmodule

// File: rtl/mgmt_cmd_regs.sv
module mgmt_cmd_regs
   import mgmt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [31:0]           reg_wdata,
   input  logic                  fin,
   input  logic [MGMT_DAT_W-1:0] cap,
   output logic                  launch,
   output mgmt_cmd_t             cmd_new,
   output logic [31:0]           reg_rdata,
   output logic                  done_evt
);
   mgmt_cmd_t cur;
   logic      ready;
   logic      accept;

   assign cmd_new = reg_wdata[27:0];
   assign accept  = reg_wr && ready;
   assign launch  = accept && ((cmd_new.opc == OPC_WRITE) || (cmd_new.opc == OPC_READ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= '0;
         ready    <= 1'b1;
         done_evt <= 1'b0;
      end else begin
         done_evt <= 1'b0;
         if (accept) begin
            cur <= cmd_new;
            if (launch) ready <= 1'b0;
         end else if (fin) begin
            ready    <= 1'b1;
            done_evt <= 1'b1;
            if (cur.opc == OPC_READ) cur.dat <= cap;
         end
      end
   end

   assign reg_rdata = {3'b000, ready, cur};
endmodule

// File: rtl/mgmt_serial_ctl.sv
module mgmt_serial_ctl
   import mgmt_pkg::*;
#(
   parameter int DIV_HALF = 2,
   parameter int PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        done_evt,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..32");
      end
   endgenerate

   logic                  launch, run, fin, rise_p, fall_p;
   mgmt_cmd_t             cmd_new;
   logic [MGMT_DAT_W-1:0] cap;

   mgmt_cmd_regs u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .fin(fin), .cap(cap), .launch(launch), .cmd_new(cmd_new),
      .reg_rdata(reg_rdata), .done_evt(done_evt)
   );

   mgmt_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc),
      .rise_p(rise_p), .fall_p(fall_p)
   );

   mgmt_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(launch), .cmd(cmd_new),
      .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
      .run(run), .fin(fin), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap)
   );
endmodule

// File: rtl/mgmt_serial_ctl_chk.sv
module mgmt_serial_ctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        done_evt,
   input logic        mdc,
   input logic        mdio_oe
);
   logic go_op, nop_op;
   assign go_op  = (reg_wdata[27:26] == 2'b01) || (reg_wdata[27:26] == 2'b10);
   assign nop_op = !go_op;

   assert_launch_clears_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_rdata[28] && go_op) |=> !reg_rdata[28]);

   assert_idle_mdc_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[28] |-> !mdc);

   assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[28] |-> !mdio_oe);

   assert_done_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> reg_rdata[28]);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> !done_evt);

   assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rdata[28]) |=> $stable(reg_rdata[27:16]));

   assert_nop_stays_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_rdata[28] && nop_op) |=>
         (reg_rdata[28] && reg_rdata[27:0] == $past(reg_wdata[27:0])));
endmodule

bind mgmt_serial_ctl mgmt_serial_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .done_evt(done_evt), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mgmt_serial_ctl_tb.sv
`timescale 1ns/1ps
module mgmt_serial_ctl_tb;
   localparam int DIV = 2;
   localparam int PRE = 32;
   localparam int NB  = PRE + 32;
   localparam int REL = PRE + 14;
   localparam int DST = PRE + 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        done_evt, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int bad = 0;
   int k = 0;
   int dcnt = 0;
   int per_err = 0;
   realtime last_rise = 0.0;
   logic [NB-1:0] bits, oes;
   logic [15:0]   phy_val = '0;

   always #2 clk = ~clk;

   mgmt_serial_ctl #(.DIV_HALF(DIV), .PRE_LEN(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .done_evt(done_evt), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   // capture each bit at rising MDC, and the period between rises
   initial forever begin
      @(posedge mdc);
      if (k < NB) begin
         bits[NB-1-k] = mdio_o;
         oes[NB-1-k]  = mdio_oe;
      end
      if (k > 0 && ($realtime - last_rise) != real'(2*DIV*4)) per_err++;
      last_rise = $realtime;
      k++;
   end

   // PHY model: change MDIO only after a falling MDC edge
   initial forever begin
      @(negedge mdc);
      if (k >= DST && k < NB) mdio_i = phy_val[NB-1-k];
      else                    mdio_i = 1'b1;
   end

   initial forever begin
      @(negedge clk);
      if (done_evt) dcnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      k = 0; dcnt = 0; per_err = 0; bits = '0; oes = '0;
   endtask

   task automatic put(input logic [31:0] w);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 5000 && !reg_rdata[28]; i++) @(negedge clk);
      chk(reg_rdata[28], "R6 ready returns", 64'(reg_rdata[28]), 64'd1);
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [63:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] rn, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, op, phy, rn, 2'b10, d};
   endfunction

   task automatic t_reset();
      chk(reg_rdata == 32'h1000_0000, "R1 reset word", 64'(reg_rdata), 64'h1000_0000);
      chk(!mdc && !mdio_oe && !done_evt, "R1 reset pins",
          64'({mdc, mdio_oe, done_evt}), 64'd0);
   endtask

   task automatic t_write(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
      logic [31:0] w;
      w = {4'b0, 2'b01, phy, rn, d};
      clear_mon();
      put(w);
      chk(!reg_rdata[28], "R2 ready low after launch", 64'(reg_rdata[28]), 64'd0);
      wait_ready();
      chk(k == NB, "R5 MDC periods per frame", 64'(k), 64'(NB));
      chk(per_err == 0, "R5 MDC period", 64'(per_err), 64'd0);
      chk(bits == mk(2'b01, phy, rn, d), "R3 write frame bits", bits, mk(2'b01, phy, rn, d));
      chk(oes == '1, "R3 MDIO driven whole frame", oes, '1);
      chk(dcnt == 1, "R6 one-cycle done pulse", 64'(dcnt), 64'd1);
      chk(reg_rdata == (w | 32'h1000_0000), "R9 readback after write",
          64'(reg_rdata), 64'(w | 32'h1000_0000));
      chk(!mdc && !mdio_oe, "R5 idle pins", 64'({mdc, mdio_oe}), 64'd0);
   endtask

   task automatic t_read(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] pv);
      logic [63:0] e;
      phy_val = pv;
      clear_mon();
      put({4'b0, 2'b10, phy, rn, 16'h5A5A});
      wait_ready();
      e = mk(2'b10, phy, rn, 16'h0);
      chk(bits[NB-1:NB-REL] == e[NB-1:NB-REL], "R4 read header bits",
          64'(bits[NB-1:NB-REL]), 64'(e[NB-1:NB-REL]));
      chk(oes[NB-1:NB-REL] == '1 && oes[NB-REL-1:0] == '0, "R4 release pattern",
          oes, {{REL{1'b1}}, {(NB-REL){1'b0}}});
      chk(reg_rdata[15:0] == pv, "R4 read data", 64'(reg_rdata[15:0]), 64'(pv));
      chk(reg_rdata[31:16] == {4'b0001, 2'b10, phy, rn}, "R4 fields kept",
          64'(reg_rdata[31:16]), 64'({4'b0001, 2'b10, phy, rn}));
      chk(dcnt == 1, "R6 done pulse on read", 64'(dcnt), 64'd1);
   endtask

   task automatic t_busy();
      logic [31:0] a;
      a = {4'b0, 2'b01, 5'h03, 5'h04, 16'h1234};
      clear_mon();
      put(a);
      repeat (20) @(negedge clk);
      put({4'b0, 2'b10, 5'h1C, 5'h0B, 16'hFFFF});
      chk(reg_rdata[27:0] == a[27:0], "R7 busy write ignored (during)",
          64'(reg_rdata[27:0]), 64'(a[27:0]));
      wait_ready();
      repeat (300) @(negedge clk);
      chk(reg_rdata == (a | 32'h1000_0000), "R7 busy write ignored (after)",
          64'(reg_rdata), 64'(a | 32'h1000_0000));
      chk(k == NB && dcnt == 1, "R7 single frame", 64'({k, dcnt}), 64'({NB, 1}));
   endtask

   task automatic t_nop(input logic [1:0] op);
      logic [31:0] w;
      w = {4'b0, op, 5'h11, 5'h07, 16'hBEEF};
      clear_mon();
      put(w);
      repeat (300) @(negedge clk);
      chk(reg_rdata == (w | 32'h1000_0000), "R8 nop stores fields, stays ready",
          64'(reg_rdata), 64'(w | 32'h1000_0000));
      chk(k == 0 && dcnt == 0, "R8 no frame, no event", 64'({k, dcnt}), 64'd0);
   endtask

   initial begin
      #800000;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write(5'h0A, 5'h13, 16'hA5C3);
      t_write(5'h1F, 5'h00, 16'h0001);
      t_read(5'h1F, 5'h00, 16'h3C96);
      t_read(5'h00, 5'h1F, 16'h8001);
      t_busy();
      t_nop(2'b00);
      t_nop(2'b11);
      t_write(5'h15, 5'h0A, 16'hFFFE);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule